// File: doc/BRIEF.md
# Move-Eliminating Register Rename

This block renames one instruction per cycle, in program order. It keeps a map from architectural to physical registers, a readiness bit for each physical register, and a reference count for each physical register. A physical register is free when its count is zero. An ordinary instruction takes the lowest-numbered free physical register as its destination and is sent on to the issue queues. A register-to-register move takes no new register. Its destination is pointed at the physical register that already holds the source, and the move is finished at rename, so it never goes to the issue queues.

Each rename reports the physical register that the destination was mapped to before. That register travels with the instruction until retirement, when it is handed back on the retire port and its count is lowered by one. Because a move adds a second reference to an existing register, a register comes back to the free pool only when every architectural mapping and every in-flight instruction that refers to it has retired. A writeback port marks a physical register ready. Since a move and its source share one physical register, a single writeback satisfies both.

Top module: `rn_move_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i, every physical register reads as ready, and physical registers from NUM_ARCH upward are free.
- R2: An accepted non-move rename (ren_is_move=0) maps its destination to the lowest-numbered free physical register and reports it on ren_dst_preg. That register's count becomes 1, it reads as not ready, ren_dst_rdy=0, and ren_dispatch=1 with ren_done=0 in that cycle.
- R3: An accepted move (ren_is_move=1) allocates no register. Its destination is mapped to the source's current physical register, which also appears on ren_dst_preg, and ren_done=1 with ren_dispatch=0.
- R4: For a move, ren_dst_rdy equals the source's readiness. When the source is pending, one writeback to the shared register makes both architectural registers read as ready afterwards.
- R5: ren_src_preg is the current mapping of ren_src. ren_src_rdy is its ready bit, and it also reads 1 when a writeback to that register arrives in the same cycle.
- R6: ren_old_preg is the mapping that ren_dst had before this rename, whether or not the request is valid.
- R7: A retire lowers the count of ret_preg by one. A register whose count reaches zero can be allocated from the next cycle on, but not in the cycle of the retire itself.
- R8: A move raises the shared register's count by one. The register therefore stays allocated until every reference to it has retired, and the count never wraps.
- R9: When no register is free, ren_ready=0 for a non-move. The request then has no effect, so no mapping changes and neither ren_done nor ren_dispatch is raised. A move is still accepted in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request present |
| ren_is_move | input | 1 | Request is a register-to-register move |
| ren_src | input | AW | Source architectural register |
| ren_dst | input | AW | Destination architectural register |
| ren_ready | output | 1 | Request can be accepted this cycle |
| ren_src_preg | output | PW | Physical register holding the source |
| ren_src_rdy | output | 1 | Source value is available |
| ren_dst_preg | output | PW | Physical register given to the destination |
| ren_dst_rdy | output | 1 | Destination value is already available (moves only) |
| ren_old_preg | output | PW | Previous mapping of the destination, to be returned at retire |
| ren_done | output | 1 | Move accepted and finished at rename |
| ren_dispatch | output | 1 | Non-move accepted, send to issue queues |
| wb_valid | input | 1 | Writeback present |
| wb_preg | input | PW | Physical register written back |
| ret_valid | input | 1 | Retire present |
| ret_preg | input | PW | Old physical register released by the retiring instruction |

## Verification
The hardest state to reach is a register shared through a move whose references retire one at a time. Only the allocation order shows whether that register is still held or has been freed. The stimulus aliases two architectural registers through a pending move, overwrites both, and retires the shared register twice. An ordinary rename after each retire shows that the shared register is skipped after the first retire and handed out after the second. The stimulus then fills the whole free pool to force the stall, sends a move and a rejected request while no register is free, and confirms through the lookup outputs that the rejected request changed nothing.

// File: rtl/rn_pkg.sv
package rn_pkg;

    // Default sizing of the rename block
    localparam int DEF_ARCH_REGS = 16;
    localparam int DEF_PHYS_REGS = 32;
    localparam int DEF_REF_MAX   = 63;

    // Where an incoming rename request goes in the cycle it is presented
    typedef enum logic [1:0] {
        RT_IDLE  = 2'd0,
        RT_ISSUE = 2'd1,
        RT_DONE  = 2'd2,
        RT_STALL = 2'd3
    } rn_route_e;

    function automatic rn_route_e route_of(input logic valid, input logic is_move,
                                           input logic have_free);
        if (!valid)
            return RT_IDLE;
        if (is_move)
            return RT_DONE;
        if (have_free)
            return RT_ISSUE;
        return RT_STALL;
    endfunction

endpackage

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
    parameter int NUM_ARCH = 16,
    parameter int AW       = 4,
    parameter int PW       = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_a_arch,
    output logic [PW-1:0] rd_a_preg,
    input  logic [AW-1:0] rd_b_arch,
    output logic [PW-1:0] rd_b_preg,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_arch,
    input  logic [PW-1:0] wr_preg
);

    logic [PW-1:0] map_q [NUM_ARCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ARCH; i++)
                map_q[i] <= PW'(i);
        end else if (wr_en) begin
            map_q[wr_arch] <= wr_preg;
        end
    end

    assign rd_a_preg = map_q[rd_a_arch];
    assign rd_b_preg = map_q[rd_b_arch];

    // A mapping written in one cycle is what the table returns in the next
    AST_MAP_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> map_q[$past(wr_arch)] == $past(wr_preg)) else $error("map write lost"); // R3

endmodule

// File: rtl/rn_ref_counts.sv
module rn_ref_counts #(
    parameter int NUM_PHYS = 32,
    parameter int NUM_ARCH = 16,
    parameter int PW       = 5,
    parameter int CW       = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc_en,
    input  logic [PW-1:0] inc_preg,
    input  logic          dec_en,
    input  logic [PW-1:0] dec_preg,
    output logic          alloc_ok,
    output logic [PW-1:0] alloc_preg
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0]       cnt_q [NUM_PHYS];
    logic [NUM_PHYS-1:0] inc_hit;
    logic [NUM_PHYS-1:0] dec_hit;
    logic [NUM_PHYS-1:0] free_vec;

    for (genvar g = 0; g < NUM_PHYS; g++) begin : g_slot
        assign inc_hit[g]  = inc_en && (inc_preg == PW'(g));
        assign dec_hit[g]  = dec_en && (dec_preg == PW'(g));
        assign free_vec[g] = (cnt_q[g] == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PHYS; i++)
                cnt_q[i] <= (i < NUM_ARCH) ? CW'(1) : '0;
        end else begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                if (inc_hit[i] && !dec_hit[i])
                    cnt_q[i] <= cnt_q[i] + CW'(1);
                else if (dec_hit[i] && !inc_hit[i])
                    cnt_q[i] <= cnt_q[i] - CW'(1);
            end
        end
    end

    // Lowest-numbered free register wins
    always_comb begin
        alloc_ok   = 1'b0;
        alloc_preg = '0;
        for (int i = NUM_PHYS - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                alloc_ok   = 1'b1;
                alloc_preg = PW'(i);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !(dec_en && dec_preg == inc_preg)) |-> cnt_q[inc_preg] != CNT_MAX)
        else $error("reference count overflow"); // R8

    AST_RETIRE_LIVE: assert property (@(posedge clk) disable iff (rst)
        dec_en |-> cnt_q[dec_preg] != '0) else $error("retire of a free register"); // R7

    AST_FRESH_ONE: assert property (@(posedge clk) disable iff (rst)
        (inc_en && cnt_q[inc_preg] == '0) |=> cnt_q[$past(inc_preg)] == CW'(1))
        else $error("fresh allocation count not one"); // R2

    AST_LAST_REF_FREES: assert property (@(posedge clk) disable iff (rst)
        (dec_en && cnt_q[dec_preg] == CW'(1) && !(inc_en && inc_preg == dec_preg))
        |=> free_vec[$past(dec_preg)]) else $error("last retire did not free"); // R7

endmodule

// File: rtl/rn_ready_bits.sv
module rn_ready_bits #(
    parameter int NUM_PHYS = 32,
    parameter int PW       = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_en,
    input  logic [PW-1:0] clr_preg,
    input  logic          set_en,
    input  logic [PW-1:0] set_preg,
    input  logic [PW-1:0] query_preg,
    output logic          query_rdy
);

    logic [NUM_PHYS-1:0] rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q <= '1;
        end else begin
            if (set_en)
                rdy_q[set_preg] <= 1'b1;
            if (clr_en)
                rdy_q[clr_preg] <= 1'b0;
        end
    end

    // Same-cycle writeback is forwarded to the lookup
    assign query_rdy = rdy_q[query_preg] || (set_en && set_preg == query_preg);

    AST_CLR_PENDING: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !rdy_q[$past(clr_preg)]) else $error("new register not pending"); // R2

    AST_WB_SETS: assert property (@(posedge clk) disable iff (rst)
        (set_en && !(clr_en && clr_preg == set_preg)) |=> rdy_q[$past(set_preg)])
        else $error("writeback lost"); // R4

endmodule

// File: rtl/rn_move_rename.sv
module rn_move_rename
    import rn_pkg::*;
#(
    parameter int NUM_ARCH = DEF_ARCH_REGS,
    parameter int NUM_PHYS = DEF_PHYS_REGS,
    parameter int REF_MAX  = DEF_REF_MAX,
    parameter int AW       = $clog2(NUM_ARCH),
    parameter int PW       = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ren_valid,
    input  logic          ren_is_move,
    input  logic [AW-1:0] ren_src,
    input  logic [AW-1:0] ren_dst,
    output logic          ren_ready,
    output logic [PW-1:0] ren_src_preg,
    output logic          ren_src_rdy,
    output logic [PW-1:0] ren_dst_preg,
    output logic          ren_dst_rdy,
    output logic [PW-1:0] ren_old_preg,
    output logic          ren_done,
    output logic          ren_dispatch,
    input  logic          wb_valid,
    input  logic [PW-1:0] wb_preg,
    input  logic          ret_valid,
    input  logic [PW-1:0] ret_preg
);

    localparam int CW = $clog2(REF_MAX + 1);

    logic          alloc_ok;
    logic [PW-1:0] alloc_preg;
    logic          fire;
    rn_route_e     route;

    assign route        = route_of(ren_valid, ren_is_move, alloc_ok);
    assign fire         = (route == RT_ISSUE) || (route == RT_DONE);
    assign ren_ready    = ren_is_move || alloc_ok;
    assign ren_done     = (route == RT_DONE);
    assign ren_dispatch = (route == RT_ISSUE);
    assign ren_dst_preg = ren_is_move ? ren_src_preg : alloc_preg;
    assign ren_dst_rdy  = ren_is_move && ren_src_rdy;

    rn_alias_table #(.NUM_ARCH(NUM_ARCH), .AW(AW), .PW(PW)) u_map (
        .clk       (clk),
        .rst       (rst),
        .rd_a_arch (ren_src),
        .rd_a_preg (ren_src_preg),
        .rd_b_arch (ren_dst),
        .rd_b_preg (ren_old_preg),
        .wr_en     (fire),
        .wr_arch   (ren_dst),
        .wr_preg   (ren_dst_preg)
    );

    rn_ref_counts #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .PW(PW), .CW(CW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .inc_en     (fire),
        .inc_preg   (ren_dst_preg),
        .dec_en     (ret_valid),
        .dec_preg   (ret_preg),
        .alloc_ok   (alloc_ok),
        .alloc_preg (alloc_preg)
    );

    rn_ready_bits #(.NUM_PHYS(NUM_PHYS), .PW(PW)) u_rdy (
        .clk        (clk),
        .rst        (rst),
        .clr_en     (route == RT_ISSUE),
        .clr_preg   (alloc_preg),
        .set_en     (wb_valid),
        .set_preg   (wb_preg),
        .query_preg (ren_src_preg),
        .query_rdy  (ren_src_rdy)
    );

    AST_MOVE_NEVER_STALLS: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && !ren_ready) |-> !ren_is_move) else $error("move stalled"); // R9

    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (rst)
        !(ren_done && ren_dispatch)) else $error("request routed twice"); // R3

endmodule

// File: tb/sim_rn_move_rename.sv
module sim_rn_move_rename;

    localparam int NA = 16;
    localparam int NP = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ren_valid = 1'b0, ren_is_move = 1'b0;
    logic [3:0] ren_src = '0, ren_dst = '0;
    logic       ren_ready, ren_src_rdy, ren_dst_rdy, ren_done, ren_dispatch;
    logic [4:0] ren_src_preg, ren_dst_preg, ren_old_preg;
    logic       wb_valid = 1'b0, ret_valid = 1'b0;
    logic [4:0] wb_preg = '0, ret_preg = '0;

    always #4 clk = ~clk;

    rn_move_rename u0 (
        .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_is_move(ren_is_move),
        .ren_src(ren_src), .ren_dst(ren_dst), .ren_ready(ren_ready),
        .ren_src_preg(ren_src_preg), .ren_src_rdy(ren_src_rdy),
        .ren_dst_preg(ren_dst_preg), .ren_dst_rdy(ren_dst_rdy),
        .ren_old_preg(ren_old_preg), .ren_done(ren_done), .ren_dispatch(ren_dispatch),
        .wb_valid(wb_valid), .wb_preg(wb_preg), .ret_valid(ret_valid), .ret_preg(ret_preg)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Reference model built from the requirements
    int m_map [NA];
    int m_cnt [NP];
    bit m_rdy [NP];
    int last_old;

    typedef struct {
        bit    full;
        bit    ready;
        int    src_p;
        bit    src_r;
        int    dst_p;
        bit    dst_r;
        int    old_p;
        bit    done;
        bit    disp;
        string tag;
    } exp_t;

    exp_t q[$];

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < NP; i++)
            if (m_cnt[i] == 0) return i;
        return -1;
    endfunction

    // Driver: drives one cycle and pushes the expected outcome
    task automatic step(input bit rv, input bit mv, input int s, input int d,
                        input bit wv, input int wp, input bit tv, input int tp,
                        input string tag);
        exp_t e;
        int   f;
        bit   fire;
        @(posedge clk); #1;
        ren_valid = rv; ren_is_move = mv; ren_src = 4'(s); ren_dst = 4'(d);
        wb_valid = wv; wb_preg = 5'(wp); ret_valid = tv; ret_preg = 5'(tp);
        f       = lowest_free();
        e.full  = rv;
        e.ready = mv || (f >= 0);
        fire    = rv && e.ready;
        e.src_p = m_map[s];
        e.src_r = m_rdy[e.src_p] || (wv && wp == e.src_p);
        e.dst_p = mv ? e.src_p : f;
        e.dst_r = mv && e.src_r;
        e.old_p = m_map[d];
        e.done  = fire && mv;
        e.disp  = fire && !mv;
        e.tag   = tag;
        q.push_back(e);
        last_old = e.old_p;
        if (wv) m_rdy[wp] = 1;
        if (tv) m_cnt[tp]--;
        if (fire) begin
            m_cnt[e.dst_p]++;
            m_map[d] = e.dst_p;
            if (!mv) m_rdy[e.dst_p] = 0;
        end
    endtask

    // Monitor: compares away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "ren_src_preg", ren_src_preg, e.src_p);
                chk(e.tag, "ren_src_rdy", ren_src_rdy, e.src_r);
                chk(e.tag, "ren_old_preg", ren_old_preg, e.old_p);
                chk(e.tag, "ren_done", ren_done, e.done);
                chk(e.tag, "ren_dispatch", ren_dispatch, e.disp);
                if (e.full) begin
                    chk(e.tag, "ren_ready", ren_ready, e.ready);
                    if (e.ready) begin
                        chk(e.tag, "ren_dst_preg", ren_dst_preg, e.dst_p);
                        chk(e.tag, "ren_dst_rdy", ren_dst_rdy, e.dst_r);
                    end
                end
            end
        end
    end

    initial begin
        #1_600_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int held;
        for (int i = 0; i < NA; i++) m_map[i] = i;
        for (int i = 0; i < NP; i++) begin
            m_cnt[i] = (i < NA) ? 1 : 0;
            m_rdy[i] = 1;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset mapping and readiness, seen through idle lookups
        step(0, 0, 3, 15, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 7, 0, 0, 0, 0, "R1");
        // R2 and R6: ordinary renames take 16, 17
        step(1, 0, 1, 2, 0, 0, 0, 0, "R2");
        step(1, 0, 2, 3, 0, 0, 0, 0, "R5");
        // R5: same-cycle writeback forwarded to the source lookup
        step(1, 0, 2, 4, 1, 16, 0, 0, "R5");
        // R3 and R4: move of a pending source shares register 17
        step(1, 1, 3, 5, 0, 0, 0, 0, "R3");
        step(0, 0, 5, 3, 0, 0, 0, 0, "R4");
        step(0, 0, 5, 3, 1, 17, 0, 0, "R4");
        step(0, 0, 3, 5, 0, 0, 0, 0, "R4");
        step(1, 1, 1, 6, 0, 0, 0, 0, "R4");
        // R8: overwrite both aliases of 17, retire them one at a time
        step(1, 0, 0, 3, 0, 0, 0, 0, "R6");
        step(1, 0, 0, 5, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 0, 1, 17, "R8");
        step(1, 0, 0, 7, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 0, 1, 17, "R7");
        step(1, 0, 0, 8, 0, 0, 0, 0, "R7");
        // R7: a register freed by a retire is not handed out in that same cycle
        step(1, 0, 0, 9, 0, 0, 1, 2, "R7");
        step(1, 0, 0, 10, 0, 0, 0, 0, "R7");
        // R9: drain the free pool
        for (int k = 0; k < 40; k++) begin
            if (lowest_free() < 0) break;
            step(1, 0, k % NA, (k + 3) % NA, 0, 0, 0, 0, "R2");
        end
        held = last_old;
        step(1, 0, 4, 10, 0, 0, 0, 0, "R9");
        step(1, 1, 4, 9, 0, 0, 0, 0, "R9");
        step(0, 0, 9, 10, 0, 0, 0, 0, "R9");
        // R7: release one register and rename again
        step(0, 0, 0, 0, 0, 0, 1, held, "R7");
        step(1, 0, 1, 11, 0, 0, 0, 0, "R7");
        step(0, 0, 11, 12, 0, 0, 0, 0, "R6");
        @(posedge clk); #1;
        ren_valid = 0; wb_valid = 0; ret_valid = 0;
        repeat (2) @(posedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule